// File: doc/BRIEF.md
# Retriggerable Watchdog With Reset Pulse Train

This block is a watchdog that sits outside a processor core with no supervisor of its own. Software running on that core changes the level of a kick input at regular intervals. While kicks keep coming within the timeout window, the reset output stays low and nothing else happens.

If the kicks stop for a full timeout, the block does not issue one reset and wait. It becomes a free-running pulse generator. The reset output carries a square wave whose high phase is wide enough to reset the processor reliably and long enough for restarted software to begin kicking again. The wave always begins with a high phase. It stops as soon as kicks return. A kick seen during a low phase stops the wave at once. A kick seen during a high phase lets that pulse finish, and then the block returns to watching.

The timeout, the high and low widths of the wave, the expected kick period and the depth of the input synchronizer are all parameters. There is no run-time configuration.

Top module: `wdog_pulse_train`

## Requirements
- R1: While rst_n is low, wd_rst_o is 0. After rst_n goes high, count the first clock edge at which rst_n is sampled high as edge 1. With no kick, wd_rst_o rises after edge TIMEOUT_CYC+2 and is 0 before that.
- R2: Every kick restarts the full timeout. Kicks no more than TIMEOUT_CYC edges apart keep wd_rst_o at 0 indefinitely. If a kick takes effect on the same edge on which the timeout would end, the kick wins.
- R3: A rising edge and a falling edge of kick_i both count as a kick. A level change first sampled on clock edge n takes effect on edge n+2: two synchronizer flops, then one edge-detect flop.
- R4: TIMEOUT_CYC consecutive edges in the watching state without a kick move the block to the expired state. wd_rst_o is 1 right after that edge.
- R5: In the expired state, wd_rst_o is a repeating square wave: 1 for HIGH_CYC cycles, then 0 for LOW_CYC cycles. It always starts with the high phase.
- R6: A kick that takes effect during a low phase returns the block to watching on that edge. wd_rst_o stays 0, and the next pulse comes only after a full new timeout without kicks.
- R7: A kick that takes effect during a high phase does not shorten the pulse. The pulse lasts its full HIGH_CYC cycles. The block then returns to watching, and the fresh timeout starts on the edge where wd_rst_o falls.
- R8: HIGH_CYC must exceed 24 cycles and must exceed twice KICK_PERIOD_CYC, and elaboration rejects other values. Every pulse of the wave is exactly HIGH_CYC cycles wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| kick_i | input | 1 | Asynchronous kick level; each change is one kick |
| wd_rst_o | output | 1 | Reset output: 0 while watching, square wave once expired |

## Verification
The hardest cases to reach are the boundaries between timing windows.

- **Kick on the last timeout edge.** The stimulus must land a kick on exactly the edge where the timeout would end. The bench places the kick toggle exactly TIMEOUT_CYC cycles after the previous one, using the three-cycle input latency.
- **One cycle too late.** A second toggle, one cycle later than the limit, must let the block expire. That toggle is then seen inside the new high phase.
- **Kicks in each phase.** Kicks that land in a low phase and in a high phase are placed at cycle numbers worked out from the wave period. The exact rise cycles that follow each kick separate the two ways a kick can stop the wave.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Operating state of the watchdog
  typedef enum logic [1:0] {
    WD_ARMED    = 2'd0,  // watching kicks, output low
    WD_PULSE_HI = 2'd1,  // expired, high phase of the reset wave
    WD_PULSE_LO = 2'd2   // expired, low phase of the reset wave
  } wd_state_e;

  // Oscillator-cycle floor a reset pulse must exceed
  localparam int unsigned WD_MIN_RESET_CYC = 24;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // Assert asynchronously, release after STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic kick_evt_o
);

  localparam int unsigned WARM_MAX = SYNC_STAGES + 1;
  localparam int unsigned WARM_W   = $clog2(WARM_MAX + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;

  generate
    if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("wdog_kick_sync: SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], kick_i};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // Either edge of the synchronized level is one kick
  assign kick_evt_o = sync_q[SYNC_STAGES-1] ^ prev_q;

  // Checker state: edges since reset, so history is never read from reset time
  logic [WARM_W-1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (warm_q != WARM_W'(WARM_MAX)) begin
      warm_q <= warm_q + WARM_W'(1);
    end
  end

  // R3: a kick event means the raw input changed exactly SYNC_STAGES samples back
  p_kick_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == WARM_W'(WARM_MAX) && kick_evt_o) |->
      ($past(kick_i, SYNC_STAGES) != $past(kick_i, SYNC_STAGES + 1)));

endmodule

// File: rtl/wdog_timeout.sv
module wdog_timeout #(
  parameter int unsigned TIMEOUT_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic kick_i,
  output logic expire_o
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          at_limit;

  always_comb begin
    at_limit = (cnt_q == LAST);
    expire_o = armed_i && !kick_i && at_limit;
    // Counter rests at zero outside the watching state
    cnt_en   = armed_i || (cnt_q != '0);
    if (!armed_i || kick_i || at_limit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4: the quiet-cycle count never passes the timeout limit
  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4: expiry is reached only from a count that was running while watching
  p_expire_from_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen
  import wdog_pkg::*;
#(
  parameter int unsigned HIGH_CYC = 30,
  parameter int unsigned LOW_CYC  = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      expire_i,
  input  logic      kick_i,
  output wd_state_e state_o,
  output logic      pulse_o,
  output logic      lo_done_o
);

  localparam int unsigned PMAX = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int unsigned PW   = $clog2(PMAX + 1);
  localparam logic [PW-1:0] HI_LAST = PW'(HIGH_CYC - 1);
  localparam logic [PW-1:0] LO_LAST = PW'(LOW_CYC - 1);

  wd_state_e     state_q, state_d;
  logic [PW-1:0] ph_q, ph_d;
  logic          ph_en;
  logic          pend_q, pend_d;
  logic          pulse_q, pulse_d;
  logic          hi_last, lo_last;

  always_comb begin
    hi_last = (ph_q == HI_LAST);
    lo_last = (ph_q == LO_LAST);
    state_d = state_q;
    ph_d    = ph_q;
    pend_d  = pend_q;
    unique case (state_q)
      WD_ARMED: begin
        if (expire_i) begin
          state_d = WD_PULSE_HI;   // wave always opens with its high phase
          ph_d    = '0;
        end
      end
      WD_PULSE_HI: begin
        if (hi_last) begin
          ph_d    = '0;
          state_d = (pend_q || kick_i) ? WD_ARMED : WD_PULSE_LO;
        end else begin
          ph_d = ph_q + PW'(1);
          if (kick_i) begin
            pend_d = 1'b1;         // remember, but let the pulse finish
          end
        end
      end
      WD_PULSE_LO: begin
        if (kick_i) begin
          state_d = WD_ARMED;      // low phase yields at once
          ph_d    = '0;
        end else if (lo_last) begin
          state_d = WD_PULSE_HI;
          ph_d    = '0;
        end else begin
          ph_d = ph_q + PW'(1);
        end
      end
      default: begin
        state_d = WD_ARMED;
        ph_d    = '0;
      end
    endcase
    if (state_d != WD_PULSE_HI) begin
      pend_d = 1'b0;
    end
    pulse_d = (state_d == WD_PULSE_HI);
    ph_en   = (state_q != WD_ARMED) || (ph_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_ARMED;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

  assign state_o   = state_q;
  assign pulse_o   = pulse_q;
  assign lo_done_o = (state_q == WD_PULSE_LO) && lo_last && !kick_i;

  // R7: a kick inside the high phase never cuts the pulse short
  p_hi_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_PULSE_HI && !hi_last) |=> (state_q == WD_PULSE_HI));

  // R6: a kick in the low phase returns to watching on that edge
  p_lo_kick_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_PULSE_LO && kick_i) |=> (state_q == WD_ARMED && !pulse_o));

  // R5: a low phase runs to its end and hands over to a high phase
  p_lo_to_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_done_o |=> pulse_o);

endmodule

// File: rtl/wdog_pulse_train.sv
module wdog_pulse_train
  import wdog_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC     = 40,
  parameter int unsigned HIGH_CYC        = 30,
  parameter int unsigned LOW_CYC         = 12,
  parameter int unsigned KICK_PERIOD_CYC = 10,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic wd_rst_o
);

  localparam int unsigned RUN_W = $clog2(HIGH_CYC + 2);

  // R8: pulse width limits are fixed at elaboration
  generate
    if (HIGH_CYC <= WD_MIN_RESET_CYC) begin : g_hi_too_short
      $error("wdog_pulse_train: HIGH_CYC must exceed the reset floor");
    end
    if (HIGH_CYC <= 2 * KICK_PERIOD_CYC) begin : g_hi_below_kicks
      $error("wdog_pulse_train: HIGH_CYC must exceed two kick periods");
    end
    if (TIMEOUT_CYC <= KICK_PERIOD_CYC || LOW_CYC == 0) begin : g_bad_timing
      $error("wdog_pulse_train: timeout or low width out of range");
    end
  endgenerate

  logic      rst_int_n;
  logic      kick_evt;
  logic      expire;
  logic      lo_done;
  logic      armed;
  wd_state_e state;

  wdog_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  wdog_kick_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_kick_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .kick_i    (kick_i),
    .kick_evt_o(kick_evt)
  );

  assign armed = (state == WD_ARMED);

  wdog_timeout #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_timeout (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .armed_i (armed),
    .kick_i  (kick_evt),
    .expire_o(expire)
  );

  wdog_pulse_gen #(
    .HIGH_CYC(HIGH_CYC),
    .LOW_CYC (LOW_CYC)
  ) u_pulse_gen (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .expire_i (expire),
    .kick_i   (kick_evt),
    .state_o  (state),
    .pulse_o  (wd_rst_o),
    .lo_done_o(lo_done)
  );

  // Checker state: length of the current high run on the output
  logic [RUN_W-1:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hi_run_q <= '0;
    end else if (!wd_rst_o) begin
      hi_run_q <= '0;
    end else if (hi_run_q != RUN_W'(HIGH_CYC + 1)) begin
      hi_run_q <= hi_run_q + RUN_W'(1);
    end
  end

  // R5 and R8: every pulse lasts exactly HIGH_CYC cycles
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(wd_rst_o) |-> (hi_run_q == RUN_W'(HIGH_CYC)));

  // R2: a kick while the output is low keeps it low on the next cycle
  p_kick_keeps_low_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kick_evt && !wd_rst_o) |=> !wd_rst_o);

  // R4: a pulse starts only after a timeout or at the end of a low phase
  p_rise_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(wd_rst_o) |-> ($past(expire) || $past(lo_done)));

  // R1: output is low whenever the internal reset is held
  always_comb begin
    if (!rst_int_n) begin
      a_low_in_reset_r1: assert (!wd_rst_o);
    end
  end

endmodule

// File: tb/wdog_pulse_train_tb.sv
module wdog_pulse_train_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T_CYC      = 40;
  localparam int H_CYC      = 30;
  localparam int L_CYC      = 12;
  localparam int KP_CYC     = 10;
  localparam int END_CYC    = 670;
  localparam int WD_CYC     = 5000;

  logic clk;
  logic rst_n;
  logic kick;
  logic wd_rst;

  int cyc;
  int n_checks;
  int n_errors;
  bit done;

  // Scoreboard: expected output level per cycle, in cycle order
  int    q_cyc[$];
  bit    q_val[$];
  string q_tag[$];

  wdog_pulse_train #(
    .TIMEOUT_CYC    (T_CYC),
    .HIGH_CYC       (H_CYC),
    .LOW_CYC        (L_CYC),
    .KICK_PERIOD_CYC(KP_CYC),
    .SYNC_STAGES    (2)
  ) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick_i  (kick),
    .wd_rst_o(wd_rst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // Driver side: push expected output levels for cycles lo..hi
  task automatic seg(input int lo, input int hi, input bit val, input string tag);
    for (int c = lo; c <= hi; c++) begin
      q_cyc.push_back(c);
      q_val.push_back(val);
      q_tag.push_back(tag);
    end
  endtask

  task automatic wait_cyc(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic toggle_at(input int c);
    wait_cyc(c);
    kick = ~kick;
  endtask

  // Monitor: pop and compare at the falling edge
  always @(negedge clk) begin
    if (rst_n && q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      check(q_tag[0], int'(wd_rst), int'(q_val[0]));
      if (q_cyc[0] != cyc) check("scoreboard order", q_cyc[0], cyc);
      void'(q_cyc.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  // Independent pulse-width measurement for R8
  int run_len;
  int last_hi;
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0;
      last_hi = 0;
    end else if (wd_rst) begin
      run_len++;
    end else if (run_len != 0) begin
      last_hi = run_len;
      run_len = 0;
    end
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    kick     = 1'b0;
    rst_n    = 1'b0;

    // Expected trace. A toggle at cycle c acts at edge c+3 (R3).
    seg(1,   41,  1'b0, "R1 quiet after reset");
    seg(42,  71,  1'b1, "R4 first pulse after timeout");
    seg(72,  83,  1'b0, "R5 low phase");
    seg(84,  113, 1'b1, "R5 second pulse");
    seg(114, 157, 1'b0, "R6 R3 kick in low phase");
    seg(158, 187, 1'b1, "R4 pulse after new timeout");
    seg(188, 227, 1'b0, "R7 R3 kick in high phase");
    seg(228, 257, 1'b1, "R7 pulse not cut short");
    seg(258, 552, 1'b0, "R2 steady kicks and boundary");
    seg(553, 582, 1'b1, "R2 late kick expires");
    seg(583, 622, 1'b0, "R7 kick on first high cycle");
    seg(623, 652, 1'b1, "R5 pulse");
    seg(653, 664, 1'b0, "R5 low width");
    seg(665, END_CYC, 1'b1, "R5 wave repeats");

    repeat (3) begin
      @(negedge clk);
      check("R1 output in reset", int'(wd_rst), 0);
    end
    rst_n = 1'b1;

    toggle_at(115);                          // R6: rising edge, acts at 118 in low phase
    toggle_at(165);                          // R7: falling edge, acts at 168 in high phase
    for (int c = 230; c <= 470; c += KP_CYC) // R2: steady kicks
      toggle_at(c);
    toggle_at(470 + T_CYC);                  // R2: acts on the final timeout edge
    toggle_at(470 + 2 * T_CYC + 1);          // one cycle late

    wait_cyc(600);
    check("R8 measured pulse width", last_hi, H_CYC);
    check("R8 pulse exceeds reset floor", int'(last_hi > 24), 1);
    check("R8 pulse exceeds two kick periods", int'(last_hi > 2 * KP_CYC), 1);

    wait_cyc(END_CYC + 2);
    check("scoreboard drained", q_cyc.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule